// File: doc/BRIEF.md
# Transpose Geometry Expander

This block sits in front of a generic N-dimensional DMA walker. It turns a transpose request into a strided multi-level transfer program that the walker can run without knowing anything about matrices. A request carries a source base, a destination base, an element mode, and a shape of M rows by N columns. The expander emits an inner length plus three repetition levels, each with its own source and destination stride. Requests that do not ask for a transpose are forwarded untouched.

A parameter picks one of two variants. The engine variant feeds a hardware transpose engine. It walks the source one bus beat per tile row, covering square tiles of NE x NE elements, where NE = STRB_W / element bytes. The tiles are ordered row-tile first, then column-tile, and each tile lands at the mirrored tile position of the output. The address-only variant needs no engine. It produces an element-granular copy with swapped strides and clears the transpose flag, so the backend performs a plain strided copy.

Each request produces exactly one result: a registered output or a one-cycle error pulse. The output is held while it is stalled.

Top module: `tpose_expander`

## Requirements
- R1: After reset `out_valid` and `err_o` are 0 and `in_ready` is 1.
- R2: A request with `in_tp`=0 appears at the outputs with every field equal to its input, including `in_mode` value 3 and zero dimensions, which are not rejected.
- R3: Engine variant, `in_tp`=1: element bytes EB = 1, 2, 4 for mode 0 (8-bit), 1 (16-bit), 2 (32-bit), and NE = STRB_W/EB. The output has `out_len` = STRB_W, `out_reps[0]` = NE, `out_reps[1]` = ceil(M/NE), `out_reps[2]` = ceil(N/NE), and `out_tp` = 1.
- R4: Engine variant strides, with padded rows P = NE*ceil(M/NE): level 0 has source N*EB and destination P*EB; level 1 has source NE*N*EB and destination STRB_W; level 2 has source STRB_W and destination NE*P*EB. As a result, tile (i,j) is written at tile (j,i).
- R5: Address-only variant, `in_tp`=1: `out_len` = EB, `out_reps` = {M, N, 1} for levels 0, 1, 2. Level 0 strides are source N*EB and destination EB. Level 1 strides are source EB and destination M*EB. Level 2 strides are 0. The destination is therefore a contiguous N x M array.
- R6: The address-only variant forwards transposes with `out_tp` = 0. Source, destination and mode are always forwarded unchanged.
- R7: A transpose request with mode 3, M = 0 or N = 0 is accepted but not forwarded. `err_o` is 1 for exactly the cycle after acceptance, and `out_valid` stays 0.
- R8: An accepted request shows `out_valid`=1 one cycle later. While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and all outputs hold.
- R9: Shapes up to M = N = 4095 produce exact results with no truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| in_valid | input | 1 | request valid |
| in_ready | output | 1 | request accepted when high with in_valid |
| in_src | input | AW | source base address |
| in_dst | input | AW | destination base address |
| in_len | input | AW | inner length (pass-through requests) |
| in_tp | input | 1 | transpose requested |
| in_mode | input | 2 | element mode: 0 8-bit, 1 16-bit, 2 32-bit, 3 reserved |
| in_rows | input | 12 | M, rows of the source |
| in_cols | input | 12 | N, columns of the source |
| in_reps | input | 3x12 | repetition counts (pass-through) |
| in_sstr | input | 3xAW | source strides (pass-through) |
| in_dstr | input | 3xAW | destination strides (pass-through) |
| out_valid | output | 1 | program valid |
| out_ready | input | 1 | walker accepts program |
| out_src | output | AW | source base |
| out_dst | output | AW | destination base |
| out_len | output | AW | inner length in bytes |
| out_tp | output | 1 | transpose engine enable |
| out_mode | output | 2 | element mode |
| out_rows | output | 12 | M |
| out_cols | output | 12 | N |
| out_reps | output | 3x12 | repetition counts per level |
| out_sstr | output | 3xAW | source stride per level |
| out_dstr | output | 3xAW | destination stride per level |
| err_o | output | 1 | one-cycle pulse for a rejected transpose |

## Verification
The hardest situation to reach is a stalled output with a second request already waiting. The design must keep `in_ready` low and hold the first program. Then, in the cycle the walker drains it, the design must take the waiting request in the same edge. The bench gets there by holding `out_ready` low across a request, presenting another for several cycles, and then releasing `out_ready` while the second request is still valid. Rejections are placed directly after forwarded programs, which checks that a rejected request leaves no stale valid behind.

// File: rtl/tpx_pkg.sv
package tpx_pkg;
  localparam int DIM_W  = 12;
  localparam int LEVELS = 3;

  typedef enum logic [1:0] {
    EL_B8  = 2'd0,
    EL_B16 = 2'd1,
    EL_B32 = 2'd2,
    EL_RSV = 2'd3
  } elem_e;
endpackage

// File: rtl/tpx_check.sv
module tpx_check
  import tpx_pkg::*;
#(
  parameter int STRB_W    = 8,
  parameter bit ADDR_ONLY = 1'b0
) (
  input  logic [1:0]       mode,
  input  logic [DIM_W-1:0] rows,
  input  logic [DIM_W-1:0] cols,
  output logic             bad
);
  // Tiles need at least four bytes per beat; the address-only walk has no tiles.
  localparam bit NARROW = !ADDR_ONLY && (STRB_W < 4);

  always_comb begin
    bad = NARROW;
    if (elem_e'(mode) == EL_RSV) bad = 1'b1;
    if (rows == '0 || cols == '0) bad = 1'b1;
  end
endmodule

// File: rtl/tpx_geom.sv
module tpx_geom
  import tpx_pkg::*;
#(
  parameter int AW        = 32,
  parameter int STRB_W    = 8,
  parameter bit ADDR_ONLY = 1'b0
) (
  input  logic [1:0]                  mode,
  input  logic [DIM_W-1:0]            rows,
  input  logic [DIM_W-1:0]            cols,
  output logic [AW-1:0]               len,
  output logic [LEVELS-1:0][DIM_W-1:0] reps,
  output logic [LEVELS-1:0][AW-1:0]   sstr,
  output logic [LEVELS-1:0][AW-1:0]   dstr
);
  localparam int LS = $clog2(STRB_W);

  logic [AW-1:0] rows_a, cols_a, eb;
  assign rows_a = AW'(rows);
  assign cols_a = AW'(cols);
  assign eb     = AW'(1) << mode;

  if (ADDR_ONLY) begin : g_addr
    // Element-granular walk: level 0 steps down source rows, level 1 across columns.
    always_comb begin
      len     = eb;
      reps[0] = rows;
      reps[1] = cols;
      reps[2] = DIM_W'(1);
      sstr[0] = cols_a << mode;
      dstr[0] = eb;
      sstr[1] = eb;
      dstr[1] = rows_a << mode;
      sstr[2] = '0;
      dstr[2] = '0;
    end
  end else begin : g_eng
    logic [3:0]       lne;       // log2 of elements per beat
    logic [DIM_W-1:0] ne, tm, tn;
    logic [DIM_W:0]   rsum, csum;
    logic [AW-1:0]    pad_a;     // rows rounded up to a whole tile

    always_comb begin
      lne   = 4'(LS) - {2'b00, mode};
      ne    = DIM_W'(1) << lne;
      rsum  = {1'b0, rows} + {1'b0, ne} - 13'd1;
      csum  = {1'b0, cols} + {1'b0, ne} - 13'd1;
      tm    = DIM_W'(rsum >> lne);
      tn    = DIM_W'(csum >> lne);
      pad_a = AW'(tm) << lne;

      len     = AW'(STRB_W);
      reps[0] = ne;
      reps[1] = tm;
      reps[2] = tn;
      sstr[0] = cols_a << mode;
      dstr[0] = pad_a << mode;
      sstr[1] = cols_a << LS;
      dstr[1] = AW'(STRB_W);
      sstr[2] = AW'(STRB_W);
      dstr[2] = pad_a << LS;
    end
  end
endmodule

// File: rtl/tpx_oreg.sv
module tpx_oreg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_bad,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         err
);
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      err       <= 1'b0;
      out_data  <= '0;
    end else begin
      err <= take && in_bad;
      if (take) begin
        out_valid <= !in_bad;
        if (!in_bad) out_data <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
    else $error("a_r8_hold: stalled output changed");

  a_r8_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid || err))
    else $error("a_r8_accept: accepted request produced no result");

  a_r7_excl: assert property (@(posedge clk) disable iff (rst)
    err |-> !out_valid)
    else $error("a_r7_excl: rejected request forwarded");
endmodule

// File: rtl/tpose_expander.sv
module tpose_expander
  import tpx_pkg::*;
#(
  parameter int AW        = 32,
  parameter int STRB_W    = 8,
  parameter bit ADDR_ONLY = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [AW-1:0]                in_src,
  input  logic [AW-1:0]                in_dst,
  input  logic [AW-1:0]                in_len,
  input  logic                         in_tp,
  input  logic [1:0]                   in_mode,
  input  logic [11:0]                  in_rows,
  input  logic [11:0]                  in_cols,
  input  logic [2:0][11:0]             in_reps,
  input  logic [2:0][AW-1:0]           in_sstr,
  input  logic [2:0][AW-1:0]           in_dstr,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [AW-1:0]                out_src,
  output logic [AW-1:0]                out_dst,
  output logic [AW-1:0]                out_len,
  output logic                         out_tp,
  output logic [1:0]                   out_mode,
  output logic [11:0]                  out_rows,
  output logic [11:0]                  out_cols,
  output logic [2:0][11:0]             out_reps,
  output logic [2:0][AW-1:0]           out_sstr,
  output logic [2:0][AW-1:0]           out_dstr,
  output logic                         err_o
);
  typedef struct packed {
    logic [AW-1:0]                  src;
    logic [AW-1:0]                  dst;
    logic [AW-1:0]                  len;
    logic                           tp;
    logic [1:0]                     mode;
    logic [DIM_W-1:0]               rows;
    logic [DIM_W-1:0]               cols;
    logic [LEVELS-1:0][DIM_W-1:0]   reps;
    logic [LEVELS-1:0][AW-1:0]      sstr;
    logic [LEVELS-1:0][AW-1:0]      dstr;
  } prog_t;
  localparam int PW = $bits(prog_t);

  logic                          chk_bad;
  logic [AW-1:0]                 g_len;
  logic [LEVELS-1:0][DIM_W-1:0]  g_reps;
  logic [LEVELS-1:0][AW-1:0]     g_sstr, g_dstr;
  prog_t                         nxt, cur;
  logic [PW-1:0]                 cur_v;

  tpx_check #(.STRB_W(STRB_W), .ADDR_ONLY(ADDR_ONLY)) u_check (
    .mode(in_mode), .rows(in_rows), .cols(in_cols), .bad(chk_bad));

  tpx_geom #(.AW(AW), .STRB_W(STRB_W), .ADDR_ONLY(ADDR_ONLY)) u_geom (
    .mode(in_mode), .rows(in_rows), .cols(in_cols),
    .len(g_len), .reps(g_reps), .sstr(g_sstr), .dstr(g_dstr));

  always_comb begin
    nxt = '{src: in_src, dst: in_dst, len: in_len, tp: in_tp, mode: in_mode,
            rows: in_rows, cols: in_cols, reps: in_reps, sstr: in_sstr,
            dstr: in_dstr};
    if (in_tp) begin
      nxt.len  = g_len;
      nxt.reps = g_reps;
      nxt.sstr = g_sstr;
      nxt.dstr = g_dstr;
      nxt.tp   = !ADDR_ONLY;
    end
  end

  tpx_oreg #(.W(PW)) u_oreg (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_bad(in_tp && chk_bad), .in_data(nxt),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(cur_v), .err(err_o));

  assign cur      = prog_t'(cur_v);
  assign out_src  = cur.src;
  assign out_dst  = cur.dst;
  assign out_len  = cur.len;
  assign out_tp   = cur.tp;
  assign out_mode = cur.mode;
  assign out_rows = cur.rows;
  assign out_cols = cur.cols;
  assign out_reps = cur.reps;
  assign out_sstr = cur.sstr;
  assign out_dstr = cur.dstr;

  if (ADDR_ONLY) begin : g_chk_addr
    a_r6_flag_clear: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> !out_tp)
      else $error("a_r6_flag_clear: address-only output carries engine flag");
  end else begin : g_chk_eng
    a_r3_beat_len: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_tp) |-> (out_len == AW'(STRB_W)))
      else $error("a_r3_beat_len: engine program inner length is not one beat");
  end
endmodule

// File: tb/sim_tpose_expander.sv
`timescale 1ns/1ps
module sim_tpose_expander;
  localparam int AW = 32;
  localparam int SW = 8;

  typedef struct packed {
    logic [AW-1:0]        src, dst, len;
    logic                 tp;
    logic [1:0]           mode;
    logic [11:0]          rows, cols;
    logic [2:0][11:0]     reps;
    logic [2:0][AW-1:0]   sstr, dstr;
  } prog_t;

  typedef struct packed {
    logic        tp;
    logic [1:0]  mode;
    logic [11:0] m, n;
    logic [31:0] src, dst;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 12'd8,    12'd8,    32'h0000_1000, 32'h0008_0000},
    '{1'b1, 2'd1, 12'd5,    12'd9,    32'h0000_2004, 32'h0009_0010},
    '{1'b1, 2'd2, 12'd1,    12'd1,    32'h0000_3000, 32'h000A_0000},
    '{1'b1, 2'd0, 12'd4095, 12'd4095, 32'h1000_0000, 32'h2000_0000},
    '{1'b1, 2'd2, 12'd3,    12'd7,    32'h0000_4010, 32'h000B_0040},
    '{1'b1, 2'd1, 12'd16,   12'd3,    32'h0000_5000, 32'h000C_0000},
    '{1'b1, 2'd0, 12'd13,   12'd2,    32'h0000_6001, 32'h000D_0003},
    '{1'b0, 2'd1, 12'd7,    12'd5,    32'hDEAD_0000, 32'hBEEF_0000},
    '{1'b0, 2'd3, 12'd0,    12'd0,    32'h0000_0044, 32'h0000_0088}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic  in_valid = 1'b0;
  logic  out_ready = 1'b1;
  prog_t di = '0;
  prog_t o0, o1;
  logic  rdy0, rdy1, v0, v1, e0, e1;

  tpose_expander #(.AW(AW), .STRB_W(SW), .ADDR_ONLY(1'b0)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy0),
    .in_src(di.src), .in_dst(di.dst), .in_len(di.len), .in_tp(di.tp),
    .in_mode(di.mode), .in_rows(di.rows), .in_cols(di.cols),
    .in_reps(di.reps), .in_sstr(di.sstr), .in_dstr(di.dstr),
    .out_valid(v0), .out_ready(out_ready),
    .out_src(o0.src), .out_dst(o0.dst), .out_len(o0.len), .out_tp(o0.tp),
    .out_mode(o0.mode), .out_rows(o0.rows), .out_cols(o0.cols),
    .out_reps(o0.reps), .out_sstr(o0.sstr), .out_dstr(o0.dstr),
    .err_o(e0));

  tpose_expander #(.AW(AW), .STRB_W(SW), .ADDR_ONLY(1'b1)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy1),
    .in_src(di.src), .in_dst(di.dst), .in_len(di.len), .in_tp(di.tp),
    .in_mode(di.mode), .in_rows(di.rows), .in_cols(di.cols),
    .in_reps(di.reps), .in_sstr(di.sstr), .in_dstr(di.dstr),
    .out_valid(v1), .out_ready(out_ready),
    .out_src(o1.src), .out_dst(o1.dst), .out_len(o1.len), .out_tp(o1.tp),
    .out_mode(o1.mode), .out_rows(o1.rows), .out_cols(o1.cols),
    .out_reps(o1.reps), .out_sstr(o1.sstr), .out_dstr(o1.dstr),
    .err_o(e1));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int ebytes(input logic [1:0] mode);
    return (mode == 2'd0) ? 1 : (mode == 2'd1) ? 2 : 4;
  endfunction

  // R3/R4: tiled program, computed with division and products
  function automatic prog_t exp_eng(input prog_t r);
    prog_t e = r;
    int eb = ebytes(r.mode);
    int ne = SW / eb;
    int tm = (int'(r.rows) + ne - 1) / ne;
    int tn = (int'(r.cols) + ne - 1) / ne;
    int pr = tm * ne;
    e.len     = AW'(SW);
    e.tp      = 1'b1;
    e.reps[0] = 12'(ne);
    e.reps[1] = 12'(tm);
    e.reps[2] = 12'(tn);
    e.sstr[0] = AW'(int'(r.cols) * eb);
    e.dstr[0] = AW'(pr * eb);
    e.sstr[1] = AW'(ne * int'(r.cols) * eb);
    e.dstr[1] = AW'(SW);
    e.sstr[2] = AW'(SW);
    e.dstr[2] = AW'(ne * pr * eb);
    return e;
  endfunction

  // R5/R6: swapped-stride element copy
  function automatic prog_t exp_ao(input prog_t r);
    prog_t e = r;
    int eb = ebytes(r.mode);
    e.len     = AW'(eb);
    e.tp      = 1'b0;
    e.reps[0] = r.rows;
    e.reps[1] = r.cols;
    e.reps[2] = 12'd1;
    e.sstr[0] = AW'(int'(r.cols) * eb);
    e.dstr[0] = AW'(eb);
    e.sstr[1] = AW'(eb);
    e.dstr[1] = AW'(int'(r.rows) * eb);
    e.sstr[2] = '0;
    e.dstr[2] = '0;
    return e;
  endfunction

  function automatic prog_t mk(input vec_t v, input int k);
    prog_t p;
    p.src  = v.src;  p.dst  = v.dst;  p.len = 32'h40 + 32'(k);
    p.tp   = v.tp;   p.mode = v.mode; p.rows = v.m; p.cols = v.n;
    for (int l = 0; l < 3; l++) begin
      p.reps[l] = 12'(k * 3 + l + 1);
      p.sstr[l] = 32'h100 * 32'(l + 1) + 32'(k);
      p.dstr[l] = 32'h2000 * 32'(l + 1) + 32'(k);
    end
    return p;
  endfunction

  task automatic send_check(input prog_t p, input string tag);
    prog_t x0, x1;
    x0 = p.tp ? exp_eng(p) : p;
    x1 = p.tp ? exp_ao(p)  : p;
    @(negedge clk);
    di = p; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(v0 && v1, tag, "valid one cycle after accept (R8)", {v0, v1}, 2'b11);
    chk(o0 === x0, tag, "engine program", o0, x0);
    chk(o1 === x1, tag, "address-only program", o1, x1);
    @(negedge clk);
    chk(!v0 && !v1 && !e0 && !e1, "R8", "drained after out_ready", {v0, v1, e0, e1}, 4'b0);
  endtask

  task automatic send_bad(input prog_t p, input string what);
    @(negedge clk);
    di = p; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(e0 && e1 && !v0 && !v1, "R7", what, {e0, e1, v0, v1}, 4'b1100);
    @(negedge clk);
    chk(!e0 && !e1 && !v0 && !v1, "R7", {what, " pulse ends"}, {e0, e1, v0, v1}, 4'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    prog_t pa, pb, xa, xb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    chk(!v0 && !v1 && !e0 && !e1 && rdy0 && rdy1, "R1", "reset state",
        {v0, v1, e0, e1, rdy0, rdy1}, 6'b000011);

    // Table walk: R2 pass-through, R3/R4 engine, R5/R6 address-only, R9 max shape
    for (int k = 0; k < NV; k++) begin
      send_check(mk(VECS[k], k), VECS[k].tp ? "R3 R4 R5 R6 R9" : "R2");
    end

    // R7: illegal transposes
    send_bad(mk('{1'b1, 2'd3, 12'd4, 12'd4, 32'h10, 32'h20}, 20), "reserved mode");
    send_bad(mk('{1'b1, 2'd0, 12'd0, 12'd4, 32'h10, 32'h20}, 21), "zero rows");
    send_bad(mk('{1'b1, 2'd2, 12'd6, 12'd0, 32'h10, 32'h20}, 22), "zero cols");
    // A legal request right after a rejection still goes through
    send_check(mk('{1'b1, 2'd1, 12'd4, 12'd4, 32'h300, 32'h700}, 23), "R7 R3 R5");

    // R8: stalled output with a second request waiting
    pa = mk('{1'b1, 2'd0, 12'd9, 12'd17, 32'hA000, 32'hB000}, 30);
    pb = mk('{1'b1, 2'd2, 12'd2, 12'd5, 32'hC000, 32'hD000}, 31);
    out_ready = 1'b0;
    @(negedge clk);
    di = pa; in_valid = 1'b1;
    @(negedge clk);
    di = pb;
    xa = exp_eng(pa);
    chk(v0 && !rdy0 && !rdy1, "R8", "stall blocks input", {v0, rdy0, rdy1}, 3'b100);
    repeat (2) @(negedge clk);
    chk(v0 && o0 === xa, "R8", "stalled output held", o0, xa);
    chk(o1 === exp_ao(pa), "R8", "stalled address-only output held", o1, exp_ao(pa));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    xb = exp_eng(pb);
    chk(v0 && o0 === xb, "R8", "waiting request taken on drain", o0, xb);
    chk(v1 && o1 === exp_ao(pb), "R8", "waiting request taken (address-only)", o1, exp_ao(pb));
    @(negedge clk);
    chk(!v0 && !v1, "R8", "empty after second drain", {v0, v1}, 2'b00);

    // R1: reset while a program is held
    out_ready = 1'b0;
    @(negedge clk);
    di = pa; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; out_ready = 1'b1;
    chk(!v0 && !v1 && rdy0 && rdy1, "R1", "reset clears held program",
        {v0, v1, rdy0, rdy1}, 4'b0011);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule